// File: doc/BRIEF.md
# Serial ADC Output Port Model

This block stands in for the digital side of a sampling converter's three-wire serial port. A host drives a conversion-start strobe and a serial clock. The block captures a parallel stimulus value at the moment a conversion is accepted. It then sends that value out on a single data line, MSB first, paced by the host's serial clock. It can be synthesized, so a host-side serial controller can be tested on real hardware or in a fast simulation without an analog model.

Both host pins are sampled by a faster system clock. A rising edge on either pin becomes a one-cycle pulse inside the block, and all state changes happen on system clock edges. While a conversion frame is running, further start strobes have no effect on the frame. Each such ignored strobe is counted, so a test environment can see when the host breaks the rule on repeated starts.

Top module: `sadc_port_model`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `sdo` is 0, `busy` is 0 and `ignored_cnt` is 0.
- R2: A rising edge on `conv_in` while `busy` is 0 is accepted. `busy` goes high, and the value on `sample_in` at that edge is the word sent. Later changes on `sample_in` do not alter the word.
- R3: A rising edge on `conv_in` while `busy` is 1 does not restart the frame or change the bit stream. It adds one to `ignored_cnt`, which holds at its all-ones value once it reaches it.
- R4: After an accepted start, data bit number k (k = 0 is the MSB) is driven on `sdo` from SCK rising edge 3+k onward. SCK edges are counted from 1 after the start, and each bit is replaced on the next SCK rising edge.
- R5: `sdo` is 0 on SCK rising edges 1 and 2 of a frame, on every SCK rising edge that carries no data bit, and on every SCK rising edge while idle. An accepted start also clears `sdo` to 0.
- R6: `busy` falls on the 16th SCK rising edge after the accepted start. The next `conv_in` rising edge is then accepted.
- R7: `WORD_W` sets the word length, 12 or 14. With 12, SCK edges 15 and 16 give 0 on `sdo`. With 14, the LSB appears on edge 16.
- R8: Each pin edge reaches the outputs within four system clock edges of the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| conv_in | input | 1 | Conversion start strobe from the host |
| sck_in | input | 1 | Serial clock from the host |
| sample_in | input | WORD_W | Parallel value captured at an accepted start |
| sdo | output | 1 | Serial data, MSB first |
| busy | output | 1 | High from an accepted start to the 16th SCK rising edge |
| ignored_cnt | output | CNT_W | Saturating count of starts ignored while busy |

## Verification
The assertions assume that every high and low phase of `conv_in` and `sck_in` lasts several system clock cycles. Under that assumption each pin edge gives exactly one edge pulse, and a start and an SCK edge are seen as separate events. The stimulus drives both pins only at falling system clock edges and holds each phase for eight cycles. Both the random frames and the directed frames inject early starts only during SCK low phases, which keeps them separate from SCK edges.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [0:0] {PH_IDLE = 1'b0, PH_RUN = 1'b1} sadc_phase_t;
  localparam int SADC_FRAME_EDGES = 16;
  localparam int SADC_LEAD_EDGES  = 2;
endpackage

// File: rtl/sadc_edge_sync.sv
module sadc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/sadc_frame_ctl.sv
module sadc_frame_ctl
  import sadc_pkg::*;
#(
  parameter int WORD_W      = 14,
  parameter int FRAME_EDGES = SADC_FRAME_EDGES,
  parameter int LEAD        = SADC_LEAD_EDGES,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_rise,
  input  logic             sck_rise,
  output logic             busy,
  output logic             accept,
  output logic             bit_go,
  output logic             zero_go,
  output logic [CNT_W-1:0] ignored
);
  localparam int EC_W = $clog2(FRAME_EDGES + 1);
  localparam logic [EC_W-1:0] LEAD_C = EC_W'(LEAD);
  localparam logic [EC_W-1:0] END_C  = EC_W'(LEAD + WORD_W);
  localparam logic [EC_W-1:0] LAST_C = EC_W'(FRAME_EDGES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  sadc_phase_t     phase_q;
  logic [EC_W-1:0] edge_cnt;

  assign busy    = (phase_q == PH_RUN);
  assign accept  = conv_rise & (phase_q == PH_IDLE);
  assign bit_go  = sck_rise & (phase_q == PH_RUN) &
                   (edge_cnt >= LEAD_C) & (edge_cnt < END_C);
  assign zero_go = accept | (sck_rise & ~bit_go);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      edge_cnt <= '0;
    end else if (accept) begin
      phase_q  <= PH_RUN;
      edge_cnt <= '0;
    end else if (phase_q == PH_RUN && sck_rise) begin
      if (edge_cnt == LAST_C) begin
        phase_q  <= PH_IDLE;
        edge_cnt <= '0;
      end else begin
        edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ignored <= '0;
    else if (conv_rise && phase_q == PH_RUN && ignored != CNT_MAX)
      ignored <= ignored + 1'b1;
  end

  // R2
  busy_rise_on_conv_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(conv_rise));
  // R6
  busy_fall_on_sck_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(sck_rise));
  // R3
  ignore_only_on_conv_chk: assert property (@(posedge clk) disable iff (rst)
    !conv_rise |=> $stable(ignored));
  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !sck_rise) |=> $stable(edge_cnt));
endmodule

// File: rtl/sadc_shift_out.sv
module sadc_shift_out #(
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              bit_go,
  input  logic              zero_go,
  input  logic [WORD_W-1:0] sample,
  output logic              sdo
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst)         word_q <= '0;
    else if (accept) word_q <= sample;
    else if (bit_go) word_q <= {word_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst)          sdo <= 1'b0;
    else if (bit_go)  sdo <= word_q[WORD_W-1];
    else if (zero_go) sdo <= 1'b0;
  end
endmodule

// File: rtl/sadc_port_model.sv
module sadc_port_model
  import sadc_pkg::*;
#(
  parameter int WORD_W     = 14,
  parameter int CNT_W      = 16,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_in,
  input  logic              sck_in,
  input  logic [WORD_W-1:0] sample_in,
  output logic              sdo,
  output logic              busy,
  output logic [CNT_W-1:0]  ignored_cnt
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pins;
  logic [NPIN-1:0] rises;
  logic accept, bit_go, zero_go;

  assign pins = {conv_in, sck_in};

  for (genvar i = 0; i < NPIN; i++) begin : g_sync
    sadc_edge_sync #(.STAGES(SYNC_STAGE)) sync_i (
      .clk (clk),
      .rst (rst),
      .pin (pins[i]),
      .rise(rises[i])
    );
  end

  sadc_frame_ctl #(
    .WORD_W     (WORD_W),
    .FRAME_EDGES(SADC_FRAME_EDGES),
    .LEAD       (SADC_LEAD_EDGES),
    .CNT_W      (CNT_W)
  ) ctl_i (
    .clk      (clk),
    .rst      (rst),
    .conv_rise(rises[1]),
    .sck_rise (rises[0]),
    .busy     (busy),
    .accept   (accept),
    .bit_go   (bit_go),
    .zero_go  (zero_go),
    .ignored  (ignored_cnt)
  );

  sadc_shift_out #(.WORD_W(WORD_W)) shf_i (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .bit_go (bit_go),
    .zero_go(zero_go),
    .sample (sample_in),
    .sdo    (sdo)
  );

  // R5
  sdo_clear_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !sdo);
endmodule

// File: tb/sadc_port_model_tb.sv
module sadc_port_model_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        conv = 1'b0;
  logic        sck = 1'b0;
  logic [13:0] smp = '0;
  logic        sdo14, busy14, sdo12, busy12;
  logic [15:0] ign14;
  logic [2:0]  ign12;

  sadc_port_model #(.WORD_W(14), .CNT_W(16)) dut_i (
    .clk(clk), .rst(rst), .conv_in(conv), .sck_in(sck), .sample_in(smp),
    .sdo(sdo14), .busy(busy14), .ignored_cnt(ign14));

  sadc_port_model #(.WORD_W(12), .CNT_W(3)) dut12_i (
    .clk(clk), .rst(rst), .conv_in(conv), .sck_in(sck), .sample_in(smp[11:0]),
    .sdo(sdo12), .busy(busy12), .ignored_cnt(ign12));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int exp_ign14 = 0;
  int exp_ign12 = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_bit(int w, logic [13:0] s, int k);
    if (k >= 3 && k <= w + 2) return int'(s[w-1-(k-3)]);
    return 0;
  endfunction

  task automatic conv_pulse();
    conv = 1'b1; ticks(8); conv = 1'b0; ticks(8);
  endtask

  task automatic frame(logic [13:0] s, logic [15:0] early_mask);
    smp = s;
    conv = 1'b1; ticks(6);
    chk("R2 busy14 after start", int'(busy14), 1);
    chk("R2 busy12 after start", int'(busy12), 1);
    chk("R5 sdo14 cleared on start", int'(sdo14), 0);
    smp = 14'($urandom);
    ticks(2); conv = 1'b0; ticks(8);
    for (int k = 1; k <= 16; k++) begin
      sck = 1'b1; ticks(6);
      chk((exp_bit(14, s, k) != 0 || (k >= 3)) ? "R4 sdo14 bit" : "R5 sdo14 lead zero",
          int'(sdo14), exp_bit(14, s, k));
      chk((k > 14) ? "R7 sdo12 tail zero" : "R4 sdo12 bit",
          int'(sdo12), exp_bit(12, s, k));
      ticks(2);
      chk((k == 16) ? "R6 busy14 end" : "R3 busy14 held", int'(busy14), (k == 16) ? 0 : 1);
      chk((k == 16) ? "R6 busy12 end" : "R3 busy12 held", int'(busy12), (k == 16) ? 0 : 1);
      sck = 1'b0; ticks(8);
      if (k < 16 && early_mask[k]) begin
        conv_pulse();
        exp_ign14++;
        if (exp_ign12 < 7) exp_ign12++;
        chk("R3 ignored14 count", int'(ign14), exp_ign14);
        chk("R3 ignored12 count saturating", int'(ign12), exp_ign12);
      end
    end
    sck = 1'b1; ticks(6);
    chk("R5 sdo14 idle zero", int'(sdo14), 0);
    chk("R5 sdo12 idle zero", int'(sdo12), 0);
    ticks(2); sck = 1'b0; ticks(8);
  endtask

  initial begin
    void'($urandom(32'd7741));
    ticks(3);
    chk("R1 sdo14 in reset", int'(sdo14), 0);
    chk("R1 busy14 in reset", int'(busy14), 0);
    chk("R1 ignored14 in reset", int'(ign14), 0);
    rst = 1'b0; ticks(1);
    chk("R1 busy12 after reset", int'(busy12), 0);
    chk("R1 sdo12 after reset", int'(sdo12), 0);
    sck = 1'b1; ticks(8);
    chk("R5 idle sck keeps sdo14 zero", int'(sdo14), 0);
    sck = 1'b0; ticks(8);
    conv = 1'b1; ticks(4);
    chk("R8 busy14 within four clocks", int'(busy14), 1);
    ticks(4); conv = 1'b0; ticks(8);
    for (int k = 1; k <= 16; k++) begin
      sck = 1'b1; ticks(8); sck = 1'b0; ticks(8);
    end
    chk("R6 busy14 idle after 16 edges", int'(busy14), 0);
    frame(14'h3FFF, 16'h0000);
    frame(14'h2AAA, 16'h0002);
    frame(14'h0000, 16'h4000);
    frame(14'h1555, 16'hFFFE);
    frame(14'h2001, 16'h0000);
    for (int n = 0; n < 24; n++) begin
      logic [15:0] m;
      m = ($urandom % 2 == 0) ? 16'h0 : (16'h1 << (1 + ($urandom % 15)));
      frame(14'($urandom), m);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule